// File: doc/BRIEF.md
# Control Register Write Guard

This block owns four processor control registers (the machine-control word, the page-table base, the feature-enable word and the task-priority word). It takes one proposed write at a time and decides whether the write faults. If the write is accepted, the block also decides what value is stored. Some bits are silently masked or forced. Other bits, and some combinations of bits across registers, make the write fault. When a write faults, nothing is stored. For the page-table base it also raises a one-cycle translation-cache invalidate request when the write calls for one.

Decode, privilege checks and the translation cache itself sit outside. A decoder presents `wr_valid` together with a register select, the raw source operand and two mode flags. `wide_mode` means the full 64-bit operand is used. `long_mode` means the extended addressing mode is active, which is true in both the 64-bit and the compatibility sub-mode. The parameter `PA_W` sets the physical address width. Base-register bits from `PA_W` up to bit 62 are reserved.

Top module: `ctlreg_guard`

## Requirements
- R1: After reset the machine-control word reads 0x60000010 and the other three registers read 0. `fault` and `tlb_inval` are low.
- R2: `wr_sel` picks the target: 0 for the machine-control word, 1 for the page-table base, 2 for the feature word, 3 for the priority word. An accepted write shows in the register one clock after it is sampled. A cycle without `wr_valid` changes no register and raises no pulse.
- R3: When `wide_mode` is low, bits 63:32 of the operand are treated as zero before any check is made.
- R4: Machine-control word:
  - Bits outside mask 0xE005003F in the low half are dropped without a fault.
  - Bit 4 is always stored as 1.
  - Any set bit in 63:32 faults.
- R5: Machine-control word: bit 31 set with bit 0 clear faults. Bit 29 set with bit 30 clear also faults.
- R6: While `long_mode` is high, two writes fault: a machine-control write with bit 31 clear, and a feature-word write with bit 5 clear.
- R7: Page-table base:
  - Bit 63 is never stored.
  - When feature bit 17 is clear, bits 2:0 and 11:5 are dropped.
  - Any set bit in 62:`PA_W` faults.
- R8: An accepted page-table base write pulses `tlb_inval` for one cycle when feature bit 17 is clear or operand bit 63 is clear. Otherwise it does not pulse.
- R9: Feature word: any set bit outside mask 0x007707FF faults. Setting bit 17 when it was clear while base bits 11:0 are nonzero also faults.
- R10: Priority word: any set bit in 63:4 faults.
- R11: A faulting write changes no register and raises no `tlb_inval`. Instead, `fault` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_sel | input | 2 | Target register select |
| wr_data | input | 64 | Raw source operand |
| wide_mode | input | 1 | Full 64-bit operand in use |
| long_mode | input | 1 | Extended addressing mode active |
| cr0_q | output | 64 | Machine-control word |
| cr3_q | output | 64 | Page-table base |
| cr4_q | output | 64 | Feature-enable word |
| cr8_q | output | 64 | Task-priority word |
| fault | output | 1 | Write rejected (one-cycle pulse) |
| tlb_inval | output | 1 | Translation-cache invalidate request (one-cycle pulse) |

## Verification
Every result of a write is due exactly one clock after the edge that samples it: the stored registers, the `fault` pulse and the `tlb_inval` pulse all appear at the same time. The driver stamps each expected item with the edge count at which its result becomes visible. The monitor samples on the falling edge and pops only items whose stamp has been reached, so it never compares a value in the cycle it is produced. Idle cycles push their own expected items, which confirms that pulses last one cycle and that registers hold.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   typedef enum logic [1:0] {
      SEL_MCW  = 2'd0,
      SEL_BASE = 2'd1,
      SEL_FEAT = 2'd2,
      SEL_PRIO = 2'd3
   } cr_sel_e;

   localparam int XLEN          = 64;
   localparam int MCW_PROT      = 0;
   localparam int MCW_EXT       = 4;
   localparam int MCW_WTHRU     = 29;
   localparam int MCW_NOCACHE   = 30;
   localparam int MCW_PAGING    = 31;
   localparam int FEAT_PAE      = 5;
   localparam int FEAT_CTXID    = 17;
   localparam int BASE_KEEPMAP  = 63;

   typedef struct packed {
      logic            fault;
      logic [XLEN-1:0] value;
   } rule_res_t;
endpackage

// File: rtl/ctlreg_mcw_rule.sv
module ctlreg_mcw_rule
   import ctlreg_pkg::*;
#(
   parameter logic [63:0] KEEP      = 64'h0000_0000_E005_003F,
   parameter bit          ET_STICKY = 1'b1
) (
   input  logic [XLEN-1:0] src,
   input  logic            long_mode,
   output rule_res_t       res
);
   localparam int HALF = XLEN / 2;
   logic [XLEN-1:0] kept;
   logic            bad_hi, bad_combo, bad_leave;

   assign bad_hi    = |src[XLEN-1:HALF];
   assign bad_combo = (src[MCW_PAGING] & ~src[MCW_PROT]) |
                      (src[MCW_WTHRU] & ~src[MCW_NOCACHE]);
   assign bad_leave = long_mode & ~src[MCW_PAGING];

   generate
      if (ET_STICKY) begin : g_sticky
         always_comb begin
            kept          = src & KEEP;
            kept[MCW_EXT] = 1'b1;
         end
      end else begin : g_plain
         assign kept = src & KEEP;
      end
   endgenerate

   assign res.fault = bad_hi | bad_combo | bad_leave;
   assign res.value = kept;
endmodule

// File: rtl/ctlreg_base_rule.sv
module ctlreg_base_rule
   import ctlreg_pkg::*;
#(
   parameter int PA_W = 52
) (
   input  logic [XLEN-1:0] src,
   input  logic            ctxid_on,
   output rule_res_t       res,
   output logic            inval_want
);
   localparam logic [XLEN-1:0] ONE        = {{(XLEN-1){1'b0}}, 1'b1};
   localparam logic [XLEN-1:0] BELOW_TOP  = (ONE << (XLEN-1)) - ONE;
   localparam logic [XLEN-1:0] BELOW_PA   = (ONE << PA_W) - ONE;
   localparam logic [XLEN-1:0] RESV_MASK  = BELOW_TOP & ~BELOW_PA;
   localparam logic [XLEN-1:0] FLAG_DROP  = 64'h0000_0000_0000_0FE7;

   logic [XLEN-1:0] trimmed;

   always_comb begin
      trimmed               = src;
      trimmed[BASE_KEEPMAP] = 1'b0;
      if (!ctxid_on) trimmed = trimmed & ~FLAG_DROP;
   end

   assign res.fault  = |(src & RESV_MASK);
   assign res.value  = trimmed;
   assign inval_want = ~ctxid_on | ~src[BASE_KEEPMAP];
endmodule

// File: rtl/ctlreg_mask_rule.sv
module ctlreg_mask_rule
   import ctlreg_pkg::*;
#(
   parameter logic [63:0] KEEP = 64'h0000_0000_0000_000F
) (
   input  logic [XLEN-1:0] src,
   output rule_res_t       res
);
   assign res.fault = |(src & ~KEEP);
   assign res.value = src;
endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
   import ctlreg_pkg::*;
#(
   parameter int          PA_W      = 52,
   parameter logic [63:0] MCW_KEEP  = 64'h0000_0000_E005_003F,
   parameter logic [63:0] FEAT_KEEP = 64'h0000_0000_0077_07FF,
   parameter int          PRIO_W    = 4,
   parameter bit          ET_STICKY = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_valid,
   input  logic [1:0]  wr_sel,
   input  logic [63:0] wr_data,
   input  logic        wide_mode,
   input  logic        long_mode,
   output logic [63:0] cr0_q,
   output logic [63:0] cr3_q,
   output logic [63:0] cr4_q,
   output logic [63:0] cr8_q,
   output logic        fault,
   output logic        tlb_inval
);
   localparam int              HALF      = XLEN / 2;
   localparam logic [XLEN-1:0] PRIO_KEEP = (64'h1 << PRIO_W) - 64'h1;
   localparam logic [XLEN-1:0] MCW_RST   = 64'h0000_0000_6000_0000 |
                                           (ET_STICKY ? 64'h10 : 64'h0);

   generate
      if (PA_W < 32 || PA_W > 62) begin : g_bad_pa
         $error("ctlreg_guard: PA_W must lie in 32..62");
      end
      if (PRIO_W < 1 || PRIO_W > 63) begin : g_bad_prio
         $error("ctlreg_guard: PRIO_W must lie in 1..63");
      end
   endgenerate

   logic [XLEN-1:0] src;
   rule_res_t       r_mcw, r_base, r_feat, r_prio;
   logic            base_inval;
   logic            feat_ctxid_bad, feat_leave_bad, feat_fault;
   logic            sel_fault;
   cr_sel_e         sel;

   assign sel = cr_sel_e'(wr_sel);
   assign src = wide_mode ? wr_data : {{HALF{1'b0}}, wr_data[HALF-1:0]};

   ctlreg_mcw_rule #(.KEEP(MCW_KEEP), .ET_STICKY(ET_STICKY)) u_mcw (
      .src(src), .long_mode(long_mode), .res(r_mcw));

   ctlreg_base_rule #(.PA_W(PA_W)) u_base (
      .src(src), .ctxid_on(cr4_q[FEAT_CTXID]), .res(r_base),
      .inval_want(base_inval));

   ctlreg_mask_rule #(.KEEP(FEAT_KEEP)) u_feat (.src(src), .res(r_feat));
   ctlreg_mask_rule #(.KEEP(PRIO_KEEP)) u_prio (.src(src), .res(r_prio));

   assign feat_ctxid_bad = src[FEAT_CTXID] & ~cr4_q[FEAT_CTXID] & (|cr3_q[11:0]);
   assign feat_leave_bad = long_mode & ~src[FEAT_PAE];
   assign feat_fault     = r_feat.fault | feat_ctxid_bad | feat_leave_bad;

   always_comb begin
      unique case (sel)
         SEL_MCW:  sel_fault = r_mcw.fault;
         SEL_BASE: sel_fault = r_base.fault;
         SEL_FEAT: sel_fault = feat_fault;
         default:  sel_fault = r_prio.fault;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr0_q     <= MCW_RST;
         cr3_q     <= '0;
         cr4_q     <= '0;
         cr8_q     <= '0;
         fault     <= 1'b0;
         tlb_inval <= 1'b0;
      end else begin
         fault     <= wr_valid & sel_fault;
         tlb_inval <= wr_valid & ~sel_fault & (sel == SEL_BASE) & base_inval;
         if (wr_valid && !sel_fault) begin
            unique case (sel)
               SEL_MCW:  cr0_q <= r_mcw.value;
               SEL_BASE: cr3_q <= r_base.value;
               SEL_FEAT: cr4_q <= r_feat.value;
               default:  cr8_q <= r_prio.value;
            endcase
         end
      end
   end
endmodule

// File: rtl/ctlreg_guard_chk.sv
module ctlreg_guard_chk #(
   parameter int          PRIO_W    = 4,
   parameter logic [63:0] FEAT_KEEP = 64'h0000_0000_0077_07FF
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_valid,
   input logic [1:0]  wr_sel,
   input logic        long_mode,
   input logic [63:0] cr0_q,
   input logic [63:0] cr3_q,
   input logic [63:0] cr4_q,
   input logic [63:0] cr8_q,
   input logic        fault,
   input logic        tlb_inval
);
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_valid) |-> (!fault && !tlb_inval && $stable(cr0_q) &&
                            $stable(cr3_q) && $stable(cr4_q) && $stable(cr8_q)));

   assert_fault_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ($stable(cr0_q) && $stable(cr3_q) && $stable(cr4_q) &&
                 $stable(cr8_q) && !tlb_inval));

   assert_ext_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cr0_q[4] && cr0_q[63:32] == 32'h0);

   assert_combo_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cr0_q[31] |-> cr0_q[0]) and (cr0_q[29] |-> cr0_q[30]));

   assert_keepmap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cr3_q[63]);

   assert_inval_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_inval |-> ($past(wr_valid) && $past(wr_sel) == 2'd1));

   assert_feat_resv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cr4_q & ~FEAT_KEEP) == 64'h0);

   assert_ctxid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cr4_q[17]) |-> $past(cr3_q[11:0]) == 12'h0);

   assert_prio_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cr8_q >> PRIO_W) == 64'h0);

   assert_pulse_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !(tlb_inval));
endmodule

bind ctlreg_guard ctlreg_guard_chk #(.PRIO_W(PRIO_W), .FEAT_KEEP(FEAT_KEEP)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
   .long_mode(long_mode), .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q),
   .cr8_q(cr8_q), .fault(fault), .tlb_inval(tlb_inval));

// File: tb/ctlreg_guard_test.sv
`timescale 1ns/1ps
module ctlreg_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [63:0] wr_data = '0;
   logic        wide_mode = 1'b1;
   logic        long_mode = 1'b0;
   logic [63:0] cr0_q, cr3_q, cr4_q, cr8_q;
   logic        fault, tlb_inval;

   always #2.5 clk = ~clk;

   ctlreg_guard uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
      .wr_data(wr_data), .wide_mode(wide_mode), .long_mode(long_mode),
      .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q), .cr8_q(cr8_q),
      .fault(fault), .tlb_inval(tlb_inval));

   typedef struct {
      int          due;
      string       req;
      logic        f, inv;
      logic [63:0] c0, c3, c4, c8;
   } exp_t;

   exp_t        exp_q[$];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [63:0] m0 = 64'h6000_0010, m3 = '0, m4 = '0, m8 = '0;
   localparam logic [63:0] BASE_RESV = 64'h7FF0_0000_0000_0000;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push(input string req, input logic f, input logic inv);
      exp_t e;
      e.due = cyc + 1; e.req = req; e.f = f; e.inv = inv;
      e.c0 = m0; e.c3 = m3; e.c4 = m4; e.c8 = m8;
      exp_q.push_back(e);
   endtask

   task automatic write(input string req, input logic [1:0] sel,
                        input logic [63:0] d, input logic wide, input logic lm);
      logic [63:0] s, nv;
      logic        f, inv;
      @(negedge clk);
      wr_valid = 1'b1; wr_sel = sel; wr_data = d; wide_mode = wide; long_mode = lm;
      s   = wide ? d : {32'h0, d[31:0]};
      inv = 1'b0;
      nv  = s;
      case (sel)
         2'd0: begin
            f  = (s[63:32] != 0) || (s[31] && !s[0]) || (s[29] && !s[30]) || (lm && !s[31]);
            nv = (s & 64'hE005_003F) | 64'h10;
         end
         2'd1: begin
            f  = (s & BASE_RESV) != 0;
            nv = s & ~(64'h1 << 63);
            if (!m4[17]) nv = nv & ~64'hFE7;
            inv = !f && (!m4[17] || !s[63]);
         end
         2'd2: f = ((s & ~64'h0077_07FF) != 0) || (s[17] && !m4[17] && m3[11:0] != 0) ||
                   (lm && !s[5]);
         default: f = s[63:4] != 0;
      endcase
      if (!f) begin
         case (sel)
            2'd0: m0 = nv;
            2'd1: m3 = nv;
            2'd2: m4 = nv;
            default: m8 = nv;
         endcase
      end
      push(req, f, inv);
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      wr_valid = 1'b0;
      push(req, 1'b0, 1'b0);
   endtask

   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.req, "fault", {63'h0, fault}, {63'h0, e.f});
         check(e.req, "tlb_inval", {63'h0, tlb_inval}, {63'h0, e.inv});
         check(e.req, "cr0", cr0_q, e.c0);
         check(e.req, "cr3", cr3_q, e.c3);
         check(e.req, "cr4", cr4_q, e.c4);
         check(e.req, "cr8", cr8_q, e.c8);
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "cr0 reset", cr0_q, 64'h6000_0010);
      check("R1", "cr3 reset", cr3_q, 64'h0);
      check("R1", "cr4 reset", cr4_q, 64'h0);
      check("R1", "cr8 reset", cr8_q, 64'h0);
      check("R1", "pulses reset", {62'h0, fault, tlb_inval}, 64'h0);

      write("R4", 2'd0, 64'h8000_0111, 1'b1, 1'b0);       // reserved bit 8 dropped
      write("R4", 2'd0, 64'h0, 1'b1, 1'b0);               // ET stays 1
      write("R5", 2'd0, 64'h8000_0000, 1'b1, 1'b0);       // paging without protection
      write("R5", 2'd0, 64'h2000_0001, 1'b1, 1'b0);       // write-through without no-cache
      write("R4", 2'd0, 64'h1_0000_0001, 1'b1, 1'b0);     // upper half set
      write("R3", 2'd0, 64'h1_0000_0001, 1'b0, 1'b0);     // upper half cleared
      idle("R2");
      idle("R11");
      write("R7", 2'd1, 64'h8000_0000_0000_1FFF, 1'b1, 1'b0);
      write("R7", 2'd1, 64'h0010_0000_0000_0000, 1'b1, 1'b0);
      write("R3", 2'd1, 64'h0010_0000_0000_2000, 1'b0, 1'b0);
      write("R9", 2'd2, 64'h0002_0000, 1'b1, 1'b0);       // context ids on, base low bits 0
      write("R8", 2'd1, 64'h8000_0000_0000_3005, 1'b1, 1'b0);
      write("R8", 2'd1, 64'h0000_0000_0000_4005, 1'b1, 1'b0);
      write("R9", 2'd2, 64'h0, 1'b1, 1'b0);
      write("R7", 2'd1, 64'h0000_0000_0000_4FFF, 1'b1, 1'b0);
      write("R9", 2'd2, 64'h0002_0000, 1'b1, 1'b0);       // low base bits nonzero
      write("R9", 2'd2, 64'h0080_0000, 1'b1, 1'b0);       // reserved bit 23
      write("R10", 2'd3, 64'h0000_000F, 1'b1, 1'b0);
      write("R10", 2'd3, 64'h0000_0010, 1'b1, 1'b0);
      write("R2", 2'd0, 64'h8000_0011, 1'b1, 1'b0);
      write("R6", 2'd0, 64'h0000_0011, 1'b1, 1'b1);       // clearing paging in long mode
      write("R6", 2'd2, 64'h0000_0000, 1'b1, 1'b1);       // clearing PAE in long mode
      write("R6", 2'd2, 64'h0000_0020, 1'b1, 1'b1);
      idle("R2");
      idle("R11");
      idle("R2");
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 pending items: actual %0d expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule